// File: doc/BRIEF.md
# Multi-Lane Serial Audio Transmitter

This block streams stereo PCM words to an external D/A converter over several data lanes that share one bit clock and one channel-select line. Each lane has its own holding register filled through a valid/ready handshake. At the start of every frame the lane moves the held left/right pair into its output word. Bits go out MSB first, and the first data bit follows each channel-select transition by one bit clock.

The block runs in one of two timing modes. In follower mode, which is the mode after reset, the bit clock and channel-select come in from outside. In leader mode the block drives both lines. It then derives the bit clock by dividing an oversampling clock input by a programmable integer. All external clocks are asynchronous to the system clock and pass through two-stage synchronizers, so every register runs on `clk`. The system clock must therefore be more than twice as fast as the quickest external toggle rate. A control bit picks which bit-clock edge launches data. The other edge is the one on which channel-select is sampled in follower mode.

Top module: `aud_serial_tx`

## Requirements
- R1: After reset the block is in follower mode with `sck_oe` and `ws_oe` low. All `sd_out` bits are 0, all `underrun` bits are 0 and every `smp_ready` is 1.
- R2: A pulse on `ctl_wr` loads the mode, launch-edge and divisor fields and clears every `underrun` bit. It also restarts framing so that the next half started is a left half. A divisor of 0 acts as 1.
- R3: In leader mode `sck_oe` and `ws_oe` are 1 and `sck_out` toggles after every `ctl_div` edges of `osclk`. Its period is therefore `ctl_div` osclk periods, which is 4*`ctl_div` system clocks when osclk toggles every 2 system clocks.
- R4: With `ctl_launch_fall`=1 the data lanes change only on falling bit-clock edges. With 0 they change only on rising edges.
- R5: In leader mode `ws_out` changes on the same bit-clock edge as the data. Each channel-select half lasts 32 bit clocks, with low meaning left and high meaning right.
- R6: In follower mode `sck_oe` and `ws_oe` stay 0. `ws_in` is sampled on the edge opposite the launch edge, and the MSB of a channel goes out on the first launch edge after a change in the sampled level has been seen.
- R7: Word format: the MSB goes out one bit clock after the channel-select transition, followed by the remaining bits down to the LSB. All later bits in the half are 0.
- R8: Each lane sends exactly one left/right pair per frame. The pair is taken from the holding register when a left half starts. All lanes share the clock and channel-select.
- R9: `smp_ready` is 1 while the lane's holding register is empty. A word is taken when `smp_valid` and `smp_ready` are both 1, and `smp_ready` is then 0 until the held pair is consumed.
- R10: If the holding register is empty when a left half starts, the lane resends its previous pair and sets its sticky `underrun` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_master | input | 1 | 1 = leader mode, 0 = follower mode |
| ctl_launch_fall | input | 1 | 1 = launch data on falling bit-clock edge |
| ctl_div | input | 8 | Bit-clock divisor of osclk |
| osclk | input | 1 | Oversampling clock (asynchronous) |
| sck_in | input | 1 | Bit clock from outside (follower mode) |
| sck_out | output | 1 | Bit clock driven in leader mode |
| sck_oe | output | 1 | Output enable for the bit-clock pin |
| ws_in | input | 1 | Channel-select from outside (follower mode) |
| ws_out | output | 1 | Channel-select driven in leader mode |
| ws_oe | output | 1 | Output enable for the channel-select pin |
| smp_valid | input | LANES | Per-lane word valid |
| smp_left | input | LANES*SMP_W | Per-lane left words, lane 0 in the low bits |
| smp_right | input | LANES*SMP_W | Per-lane right words, lane 0 in the low bits |
| smp_ready | output | LANES | Per-lane holding register empty |
| sd_out | output | LANES | Serial data lanes |
| underrun | output | LANES | Sticky per-lane underrun flags |

## Verification
Each lane carries distinct words that change from frame to frame and have different MSB and LSB values. A stuck bit, swapped channels, lanes mixed with each other or a bit order off by one slot therefore show up as a wrong decoded word. Leader mode is tried with both launch edges and two divisors, and follower mode with both launch edges. A design that ties data or channel-select to the wrong clock edge, or that samples channel-select on the launch edge, then misaligns the decoded words or fails the edge check. A run that withholds later words shows the difference between repeating the last pair and sending stale or zero data. Period measurements with divisors 3 and 0 check the divider and its zero case.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int unsigned DIV_W      = 8;
    localparam int unsigned HALF_SLOTS = 32;
    localparam int unsigned SLOT_W     = 6;
    localparam logic [SLOT_W-1:0] SLOT_IDLE = '1;

    typedef struct packed {
        logic             master;
        logic             launch_fall;
        logic [DIV_W-1:0] div;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{master: 1'b0, launch_fall: 1'b1, div: DIV_W'(1)};

    // Bit carried in a given slot of a half: slot 1 holds the MSB,
    // slots after the LSB and slot 0 carry zero. Width must stay below 32.
    function automatic logic slot_bit(input logic [SLOT_W-1:0] slot,
                                      input logic [31:0] word,
                                      input int unsigned width);
        int unsigned s;
        s = int'(slot);
        if (s >= 1 && s <= width) return word[5'(width - s)];
        return 1'b0;
    endfunction

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/aud_tx_timing.sv
module aud_tx_timing
    import aud_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              ctl_wr,
    input  logic              osc_s,
    input  logic              sck_s,
    input  logic              ws_s,
    output logic              sck_out,
    output logic              ws_out,
    output logic              launch,
    output logic              fstart,
    output logic [SLOT_W-1:0] nslot,
    output logic              nchan
);
    logic             osc_d, sck_d, sck_m, chan, ws_cap;
    logic [SLOT_W-1:0] slot;
    logic [DIV_W-1:0] div_cnt, div_eff;
    logic             osc_edge, m_tog, s_edge, s_sample, launch_lvl, launch_raw;

    always_comb begin
        div_eff    = (ctl.div == '0) ? DIV_W'(1) : ctl.div;
        launch_lvl = !ctl.launch_fall;
        osc_edge   = ctl.master && (osc_s ^ osc_d);
        m_tog      = osc_edge && (div_cnt >= div_eff - DIV_W'(1));
        s_edge     = !ctl.master && (sck_s ^ sck_d);
        s_sample   = s_edge && (sck_s != launch_lvl);
        launch_raw = (m_tog && ((!sck_m) == launch_lvl)) ||
                     (s_edge && (sck_s == launch_lvl));
        launch     = launch_raw && !ctl_wr;

        nslot  = slot;
        nchan  = chan;
        fstart = 1'b0;
        if (launch) begin
            if (ctl.master) begin
                if (slot >= SLOT_W'(HALF_SLOTS - 1)) begin
                    nchan  = !chan;
                    nslot  = '0;
                    fstart = chan;          // entering the left half
                end else begin
                    nslot = slot + SLOT_W'(1);
                end
            end else begin
                if (ws_cap != chan) begin
                    nchan  = ws_cap;
                    nslot  = SLOT_W'(1);
                    fstart = !ws_cap;
                end else if (slot != SLOT_IDLE) begin
                    nslot = slot + SLOT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_d <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            osc_d <= osc_s;
            sck_d <= sck_s;
        end
        if (rst || ctl_wr) begin
            chan    <= 1'b1;
            slot    <= SLOT_IDLE;
            div_cnt <= '0;
            sck_m   <= 1'b0;
            ws_cap  <= 1'b1;
        end else begin
            if (osc_edge) div_cnt <= m_tog ? '0 : div_cnt + DIV_W'(1);
            if (m_tog)    sck_m   <= !sck_m;
            if (s_sample) ws_cap  <= ws_s;
            if (launch) begin
                slot <= nslot;
                chan <= nchan;
            end
        end
    end

    assign sck_out = sck_m;
    assign ws_out  = chan;

    AST_WS_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        (ctl.master && !$past(ctl_wr) && (chan != $past(chan)))
        |-> ((sck_m != $past(sck_m)) && (sck_m == launch_lvl))); // R5

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ctl.master && launch) |=> (slot <= SLOT_W'(HALF_SLOTS - 1))); // R5
endmodule

// File: rtl/aud_tx_lane.sv
module aud_tx_lane
    import aud_tx_pkg::*;
#(
    parameter int unsigned SMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_left,
    input  logic [SMP_W-1:0]  in_right,
    output logic              in_ready,
    input  logic              launch,
    input  logic              fstart,
    input  logic [SLOT_W-1:0] nslot,
    input  logic              nchan,
    output logic              sd,
    output logic              underrun
);
    logic             pend_vld;
    logic [SMP_W-1:0] pend_l, pend_r, cur_l, cur_r, use_l, use_r;
    logic             take_new, nbit;

    always_comb begin
        take_new = launch && fstart && pend_vld;
        use_l    = take_new ? pend_l : cur_l;
        use_r    = take_new ? pend_r : cur_r;
        nbit     = slot_bit(nslot, 32'(nchan ? use_r : use_l), SMP_W);
    end

    assign in_ready = !pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend_l   <= '0;
            pend_r   <= '0;
            cur_l    <= '0;
            cur_r    <= '0;
            sd       <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (take_new) begin
                cur_l    <= pend_l;
                cur_r    <= pend_r;
                pend_vld <= 1'b0;
            end
            if (in_valid && !pend_vld) begin
                pend_vld <= 1'b1;
                pend_l   <= in_left;
                pend_r   <= in_right;
            end
            if (ctl_wr)                              underrun <= 1'b0;
            else if (launch && fstart && !pend_vld)  underrun <= 1'b1;
            if (launch) sd <= nbit;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready); // R9

    AST_UNDERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_wr) |-> !underrun); // R2

    AST_SD_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (sd != $past(sd)) |-> $past(launch)); // R4
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned SMP_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_wr,
    input  logic                   ctl_master,
    input  logic                   ctl_launch_fall,
    input  logic [DIV_W-1:0]       ctl_div,
    input  logic                   osclk,
    input  logic                   sck_in,
    output logic                   sck_out,
    output logic                   sck_oe,
    input  logic                   ws_in,
    output logic                   ws_out,
    output logic                   ws_oe,
    input  logic [LANES-1:0]       smp_valid,
    input  logic [LANES*SMP_W-1:0] smp_left,
    input  logic [LANES*SMP_W-1:0] smp_right,
    output logic [LANES-1:0]       smp_ready,
    output logic [LANES-1:0]       sd_out,
    output logic [LANES-1:0]       underrun
);
    localparam int unsigned N_ASYNC = 3;

    ctl_t              ctl;
    logic [N_ASYNC-1:0] async_raw, async_s;
    logic              launch, fstart, nchan;
    logic [SLOT_W-1:0] nslot;

    always_ff @(posedge clk) begin
        if (rst)         ctl <= CTL_RESET;
        else if (ctl_wr) ctl <= '{master: ctl_master, launch_fall: ctl_launch_fall, div: ctl_div};
    end

    assign async_raw = {osclk, ws_in, sck_in};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        aud_tx_sync #(.STAGES(2)) u_sync (
            .clk(clk), .rst(rst), .d(async_raw[g]), .q(async_s[g])
        );
    end

    aud_tx_timing u_timing (
        .clk(clk), .rst(rst), .ctl(ctl), .ctl_wr(ctl_wr),
        .osc_s(async_s[2]), .sck_s(async_s[0]), .ws_s(async_s[1]),
        .sck_out(sck_out), .ws_out(ws_out),
        .launch(launch), .fstart(fstart), .nslot(nslot), .nchan(nchan)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        aud_tx_lane #(.SMP_W(SMP_W)) u_lane (
            .clk(clk), .rst(rst), .ctl_wr(ctl_wr),
            .in_valid(smp_valid[l]),
            .in_left(smp_left[l*SMP_W +: SMP_W]),
            .in_right(smp_right[l*SMP_W +: SMP_W]),
            .in_ready(smp_ready[l]),
            .launch(launch), .fstart(fstart), .nslot(nslot), .nchan(nchan),
            .sd(sd_out[l]), .underrun(underrun[l])
        );
    end

    assign sck_oe = ctl.master;
    assign ws_oe  = ctl.master;

    AST_FOLLOWER_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!sck_oe && !ws_oe)); // R1
endmodule

// File: tb/tb_aud_serial_tx.sv
module tb_aud_serial_tx;
    localparam int LANES = 4;
    localparam int W     = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic osclk = 1'b0;
    initial begin #5; forever #40 osclk = ~osclk; end

    logic rst, ctl_wr, ctl_master, ctl_launch_fall;
    logic [7:0] ctl_div;
    logic sck_in, ws_in, sck_out, sck_oe, ws_out, ws_oe;
    logic [LANES-1:0] smp_valid, smp_ready, sd_out, underrun;
    logic [LANES*W-1:0] smp_left, smp_right;

    aud_serial_tx #(.LANES(LANES), .SMP_W(W)) dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_master(ctl_master),
        .ctl_launch_fall(ctl_launch_fall), .ctl_div(ctl_div), .osclk(osclk),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .ws_in(ws_in), .ws_out(ws_out), .ws_oe(ws_oe),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .smp_ready(smp_ready), .sd_out(sd_out), .underrun(underrun)
    );

    int n_chk = 0, n_bad = 0;
    bit started, prev_ws;
    int k, frames, pad_bad, half_bad, edge_bad;
    logic [W-1:0] acc [LANES];
    logic [W-1:0] rxl [LANES];

    function automatic logic [W-1:0] exp_l(int lane, int f);
        return W'(16'h8001 ^ (lane * 16'h1230) ^ (f * 16'h0503));
    endfunction
    function automatic logic [W-1:0] exp_r(int lane, int f);
        return ~exp_l(lane, f) ^ W'(16'h00F0);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ctl_wr = 0; ctl_master = 0; ctl_launch_fall = 1; ctl_div = 8'd1;
        sck_in = 0; ws_in = 1; smp_valid = '0; smp_left = '0; smp_right = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_ctl(bit m, bit lf, int dv);
        @(negedge clk);
        ctl_wr = 1; ctl_master = m; ctl_launch_fall = lf; ctl_div = 8'(dv);
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic push_all(int f);
        while (smp_ready != '1) @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            smp_left[l*W +: W]  = exp_l(l, f);
            smp_right[l*W +: W] = exp_r(l, f);
        end
        smp_valid = '1;
        @(negedge clk);
        smp_valid = '0;
    endtask

    task automatic dec_init();
        started = 0; prev_ws = 1; k = 0; frames = 0; pad_bad = 0; half_bad = 0; edge_bad = 0;
    endtask

    // receiver: one call per sampling edge
    task automatic take(logic ws, logic [LANES-1:0] sd, int npush, string req);
        if (ws != prev_ws) begin
            if (started && k != 31) half_bad++;
            prev_ws = ws; k = 0;
            if (!ws) started = 1;
        end else if (k < 63) k++;
        if (started && k >= 1) begin
            for (int l = 0; l < LANES; l++) begin
                if (k <= W) acc[l] = {acc[l][W-2:0], sd[l]};
                else if (sd[l]) pad_bad++;
            end
            if (k == W) begin
                if (!ws) begin
                    for (int l = 0; l < LANES; l++) rxl[l] = acc[l];
                end else begin
                    int ef;
                    ef = (frames < npush) ? frames : npush - 1;
                    for (int l = 0; l < LANES; l++) begin
                        chk(rxl[l] == exp_l(l, ef), req, $sformatf("lane %0d frame %0d left", l, frames), rxl[l], exp_l(l, ef));
                        chk(acc[l] == exp_r(l, ef), req, $sformatf("lane %0d frame %0d right", l, frames), acc[l], exp_r(l, ef));
                    end
                    frames++;
                end
            end
        end
    endtask

    task automatic test_reset();
        do_reset();
        chk(sck_oe == 0, "R1", "sck_oe", sck_oe, 0);
        chk(ws_oe == 0, "R1", "ws_oe", ws_oe, 0);
        chk(sd_out == '0, "R1", "sd_out", sd_out, 0);
        chk(underrun == '0, "R1", "underrun", underrun, 0);
        chk(smp_ready == '1, "R1 R9", "smp_ready", smp_ready, 4'hF);
    endtask

    // leader mode: R3 R4 R5 R7 R8 (R10 when npush < nframes)
    task automatic test_master(bit lf, int dv, int nframes, int npush);
        logic lvl, psck, pws;
        logic [LANES-1:0] psd;
        int cyc;
        do_reset();
        dec_init();
        push_all(0);
        chk(smp_ready == '0, "R9", "ready after accept", smp_ready, 0);
        write_ctl(1, lf, dv);
        lvl = !lf; psck = sck_out; pws = ws_out; psd = sd_out; cyc = 0;
        fork
            begin
                for (int f = 1; f < npush; f++) push_all(f);
            end
            begin
                while (frames < nframes && cyc < 20000) begin
                    @(negedge clk); cyc++;
                    if ((sd_out != psd || ws_out != pws) && !(sck_out != psck && sck_out == lvl)) edge_bad++;
                    if (sck_out != psck && sck_out != lvl) take(ws_out, sd_out, npush, "R8");
                    psck = sck_out; pws = ws_out; psd = sd_out;
                end
            end
        join
        chk(cyc < 20000, "R8", "leader frames decoded", frames, nframes);
        chk(edge_bad == 0, "R4 R5", "changes off launch edge", edge_bad, 0);
        chk(pad_bad == 0, "R7", "nonzero pad bits", pad_bad, 0);
        chk(half_bad == 0, "R5", "half not 32 clocks", half_bad, 0);
        chk(sck_oe && ws_oe, "R3", "leader oe", {sck_oe, ws_oe}, 3);
        chk(underrun == ((npush < nframes) ? 4'hF : 4'h0), "R10", "underrun flags",
            underrun, (npush < nframes) ? 4'hF : 4'h0);
        if (npush < nframes) begin
            write_ctl(1, lf, dv);
            chk(underrun == '0, "R2", "underrun cleared by write", underrun, 0);
        end
    endtask

    // follower mode: R6 R7 R8
    task automatic test_slave(bit lf, int nframes, int npush);
        logic lvl;
        int b;
        do_reset();
        dec_init();
        push_all(0);
        write_ctl(0, lf, 1);
        lvl = !lf; b = 0;
        fork
            begin
                for (int f = 1; f < npush; f++) push_all(f);
            end
            begin
                while (frames < nframes && b < 1000) begin
                    sck_in = lvl; ws_in = ((b % 64) >= 32);
                    repeat (8) @(negedge clk);
                    take(ws_in, sd_out, npush, "R6");
                    sck_in = !lvl;
                    repeat (8) @(negedge clk);
                    if (sck_oe || ws_oe) edge_bad++;
                    b++;
                end
            end
        join
        chk(b < 1000, "R6", "follower frames decoded", frames, nframes);
        chk(edge_bad == 0, "R6", "pins driven in follower mode", edge_bad, 0);
        chk(pad_bad == 0, "R7", "nonzero pad bits", pad_bad, 0);
        chk(underrun == '0, "R10", "no underrun when fed", underrun, 0);
    endtask

    task automatic test_period(int dv, int expc, string req);
        int c, t0;
        logic p;
        do_reset();
        write_ctl(1, 1, dv);
        c = 0; t0 = -1; p = sck_out;
        while (c < 2000) begin
            @(negedge clk); c++;
            if (sck_out && !p) begin
                if (t0 < 0) t0 = c;
                else break;
            end
            p = sck_out;
        end
        chk((c - t0) == expc, req, $sformatf("sck period div %0d", dv), c - t0, expc);
    endtask

    initial begin
        test_reset();
        test_master(1, 2, 3, 3);
        test_master(0, 1, 3, 3);
        test_master(1, 2, 3, 1);
        test_slave(1, 3, 3);
        test_slave(0, 2, 2);
        test_period(3, 12, "R3");
        test_period(0, 4, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule